// File: doc/BRIEF.md
# Pseudo-Random Test Pattern Engine

This block is the test-pattern engine of one line channel. Its transmit side either passes user data through or replaces it with a fixed level or with a pseudo-random sequence. Two sequences are available: a 2^15-1 maximal-length sequence and a 2^20-1 sequence whose zero runs are capped. The output can optionally be inverted. Its receive side watches the incoming serial stream for the same sequence and locks onto it by itself. It judges synchronization over back-to-back 64-bit windows, counts bit errors in a saturating counter and raises a maskable interrupt when the sync state changes.

Each bit period is marked by a one-cycle `bitEn` pulse in the system clock domain. Every sequential element that carries pattern state advances only on that pulse. Configuration is applied as static inputs. The count is cleared by a read strobe. The sticky interrupt bit is cleared by a write-one-to-clear pulse.

Top module: `test_pattern_engine`

## Requirements
- R1: After reset `txDataOut`, `syncFlag`, `errCount` and `irqOut` are 0. Both sequence registers start all ones, and the bit-window position starts at 0.
- R2: On each `bitEn`, `txDataOut` is updated as follows. With `patMode` = 01 it becomes 1. With `patMode` = 00 and `clkSel` = 1 it becomes 0. With `patMode` = 00 and `clkSel` = 0, or with `patMode` = 11, it takes `txDataIn`.
- R3: With `patMode` = 10 and `longSeq` = 0, the sequence register s advances on each `bitEn` by shifting in b = s[14] xor s[13] at the low end. The bit sent is b, so the newest bit goes out first.
- R4: With `longSeq` = 1 the feedback is b = s[19] xor s[16]. The bit sent is b, except that it is forced to 1 when the previous 14 bits sent were all 0. The register still takes b.
- R5: `patInvert` = 1 inverts the sequence bit before it leaves on `txDataOut`. It also inverts `rxDataIn` before comparison, so an inverted stream locks.
- R6: The receive windows are consecutive groups of 64 `bitEn` pulses counted from reset. At the end of a window, sync is declared when the window held 6 or fewer bit errors.
- R7: At the end of a window holding more than 6 bit errors, sync is dropped. `syncFlag` changes only on the last bit of a window.
- R8: While out of sync, the receive register shifts in the received (de-inverted) bit, so the checker locks onto a clean stream without help. While in sync it runs free on its own feedback.
- R9: When `errSel` = 00, every `bitEn` whose received bit differs from the expected bit increments `errCount`. The count saturates at 0xFFFF.
- R10: `cntRdStrobe` clears `errCount` to 0 and takes priority over an increment in the same cycle.
- R11: With `irqAnyEdge` = 0, only a 0-to-1 change of sync sets the sticky bit. With `irqAnyEdge` = 1, any change of sync sets it.
- R12: `irqOut` equals the sticky bit AND `irqMask`. `stickyClr` clears the sticky bit, but a set in the same cycle wins.
- R13: Without `bitEn`, `txDataOut` and `syncFlag` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bitEn | input | 1 | One-cycle strobe per bit period |
| txDataIn | input | 1 | User transmit data |
| rxDataIn | input | 1 | Received serial data |
| patMode | input | 2 | Transmit pattern select |
| clkSel | input | 1 | Selects all-zeros instead of pass-through in mode 00 |
| patInvert | input | 1 | Inverts sequence on transmit and receive |
| longSeq | input | 1 | 0: 2^15-1 sequence, 1: zero-capped 2^20-1 sequence |
| errSel | input | 2 | Error-count source select; 00 counts sequence errors |
| irqAnyEdge | input | 1 | Sticky bit captures any sync change when 1 |
| irqMask | input | 1 | Interrupt enable |
| stickyClr | input | 1 | Write-one-to-clear pulse for the sticky bit |
| cntRdStrobe | input | 1 | Clears the error count |
| txDataOut | output | 1 | Transmit serial data |
| syncFlag | output | 1 | Receive sequence synchronized |
| errCount | output | 16 | Saturating bit-error count |
| irqOut | output | 1 | Interrupt request |

## Verification
The bench aligns to the 64-bit windows and injects exactly six errors, then exactly seven. A checker that placed the threshold one off, or that slid the window instead of hopping it, would keep or drop sync in the wrong window. It flips the inversion mid-stream and switches to the long sequence to confirm that the checker relocks by reloading. A design that compared before de-inverting, or that forced ones into its own register, would never regain sync. It drives a stream that misses on every bit for more than 65,535 bits, to catch a counter that wraps to zero. It then pulses the read strobe on an erroring bit to catch an increment that beats the clear. Sync losses with edge select 0 and with edge select 1 separate a sticky bit that follows the level from one that captures only the chosen edge.

// File: rtl/tpe_pkg.sv
package tpe_pkg;

  typedef enum logic [1:0] {
    PAT_DATA = 2'b00,
    PAT_ONES = 2'b01,
    PAT_SEQ  = 2'b10,
    PAT_RSVD = 2'b11
  } patMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic step;    // one bit period elapses
    logic reload;  // receive register follows received data
  } tpeStrobe_t;

endpackage

// File: rtl/tpe_seq_core.sv
// Sequence register with zero-run limiting, shared by generator and checker.
module tpe_seq_core #(
  parameter int SHORT_LEN  = 15,
  parameter int SHORT_TAP  = 14,
  parameter int LONG_LEN   = 20,
  parameter int LONG_TAP   = 17,
  parameter int ZERO_LIMIT = 14
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic longSel,
  input  logic reload,
  input  logic loadBit,
  input  logic runBit,
  output logic outBit
);
  localparam int SW = LONG_LEN;
  localparam int ZW = $clog2(ZERO_LIMIT + 1);

  logic [SW-1:0] seqState;
  logic [ZW-1:0] zeroRun;
  logic          rawBit;
  logic          forceOne;

  assign rawBit   = longSel ? (seqState[LONG_LEN-1] ^ seqState[LONG_TAP-1])
                            : (seqState[SHORT_LEN-1] ^ seqState[SHORT_TAP-1]);
  assign forceOne = longSel && (zeroRun == ZW'(ZERO_LIMIT));
  assign outBit   = rawBit | forceOne;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seqState <= '1;
      zeroRun  <= '0;
    end else if (step) begin
      seqState <= {seqState[SW-2:0], reload ? loadBit : rawBit};
      if (runBit)                          zeroRun <= '0;
      else if (zeroRun != ZW'(ZERO_LIMIT)) zeroRun <= zeroRun + ZW'(1);
    end
  end
endmodule

// File: rtl/tpe_datapath.sv
module tpe_datapath
  import tpe_pkg::*;
#(
  parameter int SHORT_LEN  = 15,
  parameter int SHORT_TAP  = 14,
  parameter int LONG_LEN   = 20,
  parameter int LONG_TAP   = 17,
  parameter int ZERO_LIMIT = 14
) (
  input  logic       clk,
  input  logic       rst_n,
  input  tpeStrobe_t strobe,
  input  logic       txDataIn,
  input  logic       rxDataIn,
  input  logic [1:0] patMode,
  input  logic       clkSel,
  input  logic       patInvert,
  input  logic       longSeq,
  output logic       txDataOut,
  output logic       bitErr
);
  logic genStep, genOut, chkOut, rxBit;

  assign genStep = strobe.step && (patMode_e'(patMode) == PAT_SEQ);
  assign rxBit   = rxDataIn ^ patInvert;

  tpe_seq_core #(
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP), .LONG_LEN(LONG_LEN),
    .LONG_TAP(LONG_TAP), .ZERO_LIMIT(ZERO_LIMIT)
  ) u_gen (
    .clk(clk), .rst_n(rst_n), .step(genStep), .longSel(longSeq),
    .reload(1'b0), .loadBit(1'b0), .runBit(genOut), .outBit(genOut)
  );

  tpe_seq_core #(
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP), .LONG_LEN(LONG_LEN),
    .LONG_TAP(LONG_TAP), .ZERO_LIMIT(ZERO_LIMIT)
  ) u_chk (
    .clk(clk), .rst_n(rst_n), .step(strobe.step), .longSel(longSeq),
    .reload(strobe.reload), .loadBit(rxBit), .runBit(rxBit), .outBit(chkOut)
  );

  assign bitErr = rxBit ^ chkOut;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txDataOut <= 1'b0;
    end else if (strobe.step) begin
      unique case (patMode_e'(patMode))
        PAT_SEQ:  txDataOut <= genOut ^ patInvert;
        PAT_ONES: txDataOut <= 1'b1;
        PAT_DATA: txDataOut <= clkSel ? 1'b0 : txDataIn;
        PAT_RSVD: txDataOut <= txDataIn;
        default:  txDataOut <= txDataIn;
      endcase
    end
  end
endmodule

// File: rtl/tpe_ctrl.sv
module tpe_ctrl
  import tpe_pkg::*;
#(
  parameter int WIN_LEN   = 64,
  parameter int ERR_LIMIT = 6,
  parameter int CNT_W     = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitEn,
  input  logic             bitErr,
  input  logic [1:0]       errSel,
  input  logic             irqAnyEdge,
  input  logic             irqMask,
  input  logic             stickyClr,
  input  logic             cntRdStrobe,
  output tpeStrobe_t       strobe,
  output logic             syncFlag,
  output logic [CNT_W-1:0] errCount,
  output logic             irqOut
);
  localparam int WW     = $clog2(WIN_LEN);
  localparam int EW     = $clog2(ERR_LIMIT + 2);
  localparam int ERRSAT = ERR_LIMIT + 1;

  logic [WW-1:0] winPos;
  logic [EW-1:0] winErr, winErrNext;
  logic          lastBit, syncNext, stickySet, sticky, countHit;

  assign strobe.step   = bitEn;
  assign strobe.reload = !syncFlag;

  assign lastBit    = (winPos == WW'(WIN_LEN - 1));
  assign winErrNext = (bitErr && winErr != EW'(ERRSAT)) ? winErr + EW'(1) : winErr;

  always_comb begin
    syncNext = syncFlag;
    if (bitEn && lastBit) syncNext = (winErrNext <= EW'(ERR_LIMIT));
  end

  assign stickySet = irqAnyEdge ? (syncNext != syncFlag) : (syncNext && !syncFlag);
  assign countHit  = bitEn && bitErr && (errSel == 2'b00) && (errCount != '1);
  assign irqOut    = sticky && irqMask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winPos   <= '0;
      winErr   <= '0;
      syncFlag <= 1'b0;
    end else begin
      syncFlag <= syncNext;
      if (bitEn) begin
        winPos <= lastBit ? '0 : winPos + WW'(1);
        winErr <= lastBit ? '0 : winErrNext;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           errCount <= '0;
    else if (cntRdStrobe) errCount <= '0;
    else if (countHit)    errCount <= errCount + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         sticky <= 1'b0;
    else if (stickySet) sticky <= 1'b1;
    else if (stickyClr) sticky <= 1'b0;
  end
endmodule

// File: rtl/test_pattern_engine.sv
module test_pattern_engine
  import tpe_pkg::*;
#(
  parameter int SHORT_LEN  = 15,
  parameter int SHORT_TAP  = 14,
  parameter int LONG_LEN   = 20,
  parameter int LONG_TAP   = 17,
  parameter int ZERO_LIMIT = 14,
  parameter int WIN_LEN    = 64,
  parameter int ERR_LIMIT  = 6,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bitEn,
  input  logic             txDataIn,
  input  logic             rxDataIn,
  input  logic [1:0]       patMode,
  input  logic             clkSel,
  input  logic             patInvert,
  input  logic             longSeq,
  input  logic [1:0]       errSel,
  input  logic             irqAnyEdge,
  input  logic             irqMask,
  input  logic             stickyClr,
  input  logic             cntRdStrobe,
  output logic             txDataOut,
  output logic             syncFlag,
  output logic [CNT_W-1:0] errCount,
  output logic             irqOut
);
  tpeStrobe_t strobe;
  logic       bitErr;

  tpe_ctrl #(.WIN_LEN(WIN_LEN), .ERR_LIMIT(ERR_LIMIT), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .bitErr(bitErr), .errSel(errSel),
    .irqAnyEdge(irqAnyEdge), .irqMask(irqMask), .stickyClr(stickyClr),
    .cntRdStrobe(cntRdStrobe), .strobe(strobe), .syncFlag(syncFlag),
    .errCount(errCount), .irqOut(irqOut)
  );

  tpe_datapath #(
    .SHORT_LEN(SHORT_LEN), .SHORT_TAP(SHORT_TAP), .LONG_LEN(LONG_LEN),
    .LONG_TAP(LONG_TAP), .ZERO_LIMIT(ZERO_LIMIT)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .txDataIn(txDataIn),
    .rxDataIn(rxDataIn), .patMode(patMode), .clkSel(clkSel),
    .patInvert(patInvert), .longSeq(longSeq), .txDataOut(txDataOut),
    .bitErr(bitErr)
  );
endmodule

// File: rtl/tpe_checker.sv
module tpe_checker #(
  parameter int WIN_LEN = 64,
  parameter int CNT_W   = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bitEn,
  input logic [1:0]       patMode,
  input logic             clkSel,
  input logic             txDataOut,
  input logic             syncFlag,
  input logic [CNT_W-1:0] errCount,
  input logic             cntRdStrobe,
  input logic             irqMask,
  input logic             irqOut
);
  localparam int WW = $clog2(WIN_LEN);
  logic [WW-1:0] seenBits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     seenBits <= '0;
    else if (bitEn) seenBits <= (seenBits == WW'(WIN_LEN - 1)) ? '0 : seenBits + WW'(1);
  end

  assert_ones_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitEn && patMode == 2'b01 |=> txDataOut);
  assert_zeros_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bitEn && patMode == 2'b00 && clkSel |=> !txDataOut);
  assert_window_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    syncFlag != $past(syncFlag) |-> $past(bitEn) && $past(seenBits) == WW'(WIN_LEN - 1));
  assert_no_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    errCount == '1 && !cntRdStrobe |=> errCount == '1);
  assert_unit_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !cntRdStrobe |=> errCount == $past(errCount) || errCount == $past(errCount) + CNT_W'(1));
  assert_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cntRdStrobe |=> errCount == '0);
  assert_masked_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !irqMask |-> !irqOut);
  assert_rise_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncFlag) && irqMask |-> irqOut);
  assert_hold_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !bitEn |=> $stable(txDataOut) && $stable(syncFlag));
endmodule

bind test_pattern_engine tpe_checker #(.WIN_LEN(WIN_LEN), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .patMode(patMode), .clkSel(clkSel),
  .txDataOut(txDataOut), .syncFlag(syncFlag), .errCount(errCount),
  .cntRdStrobe(cntRdStrobe), .irqMask(irqMask), .irqOut(irqOut)
);

// File: tb/test_pattern_engine_tb.sv
module test_pattern_engine_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic bitEn = 0, txDataIn = 0, rxDataIn = 0;
  logic [1:0] patMode = 2'b00, errSel = 2'b00;
  logic clkSel = 0, patInvert = 0, longSeq = 0, irqAnyEdge = 0, irqMask = 1;
  logic stickyClr = 0, cntRdStrobe = 0;
  logic txDataOut, syncFlag, irqOut;
  logic [15:0] errCount;

  int nChecks = 0, nFail = 0;

  // reference state
  logic [19:0] gSt = '1, cSt = '1, sSt = '1;
  int gZ = 0, cZ = 0, sZ = 0, winCnt = 0, winErr = 0, mCnt = 0;
  bit mSync = 0, mSticky = 0, mTx = 0;

  always #2 clk = ~clk;

  test_pattern_engine u_dut (
    .clk(clk), .rst_n(rst_n), .bitEn(bitEn), .txDataIn(txDataIn), .rxDataIn(rxDataIn),
    .patMode(patMode), .clkSel(clkSel), .patInvert(patInvert), .longSeq(longSeq),
    .errSel(errSel), .irqAnyEdge(irqAnyEdge), .irqMask(irqMask), .stickyClr(stickyClr),
    .cntRdStrobe(cntRdStrobe), .txDataOut(txDataOut), .syncFlag(syncFlag),
    .errCount(errCount), .irqOut(irqOut)
  );

  function automatic bit fbBit(input logic [19:0] s, input bit lng);
    return lng ? (s[19] ^ s[16]) : (s[14] ^ s[13]);
  endfunction

  function automatic int runNext(input int z, input bit b);
    return b ? 0 : ((z == 14) ? 14 : z + 1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // next bit of the bench-side sequence source feeding rxDataIn
  function automatic bit srcBit(input bit flip);
    bit r, o;
    r = fbBit(sSt, longSeq);
    o = r | (longSeq && sZ == 14);
    sSt = {sSt[18:0], r};
    sZ = runNext(sZ, o);
    return o ^ patInvert ^ flip;
  endfunction

  // one clock: drive at negedge, update reference, compare at next negedge
  task automatic step(input bit en, input bit txIn, input bit rxIn, input bit clr, input bit rd);
    bit o, r, d, e, err, ns, setS;
    bitEn = en; txDataIn = txIn; rxDataIn = rxIn; stickyClr = clr; cntRdStrobe = rd;
    ns = mSync; setS = 0;
    if (en) begin
      case (patMode)
        2'b10: begin
          r = fbBit(gSt, longSeq);
          o = r | (longSeq && gZ == 14);
          mTx = o ^ patInvert;
          gSt = {gSt[18:0], r};
          gZ = runNext(gZ, o);
        end
        2'b01: mTx = 1;
        2'b00: mTx = clkSel ? 1'b0 : txIn;
        default: mTx = txIn;
      endcase
      d = rxIn ^ patInvert;
      r = fbBit(cSt, longSeq);
      e = r | (longSeq && cZ == 14);
      err = d ^ e;
      cSt = {cSt[18:0], mSync ? r : d};
      cZ = runNext(cZ, d);
      if (err && errSel == 2'b00 && mCnt < 65535) mCnt++;
      if (err && winErr < 7) winErr++;
      if (winCnt == 63) begin
        ns = (winErr <= 6);
        winErr = 0;
        winCnt = 0;
      end else winCnt++;
      setS = irqAnyEdge ? (ns != mSync) : (ns && !mSync);
    end
    if (rd) mCnt = 0;
    mSync = ns;
    if (setS) mSticky = 1;
    else if (clr) mSticky = 0;
    @(negedge clk);
    bitEn = 0; stickyClr = 0; cntRdStrobe = 0;
    check(txDataOut == mTx, patMode == 2'b10 ? (longSeq ? "R4 tx" : "R3 tx") : "R2 tx",
          txDataOut, mTx);
    check(syncFlag == mSync, "R6/R7 sync", syncFlag, mSync);
    check(errCount == mCnt[15:0], "R9 count", errCount, mCnt);
    check(irqOut == (mSticky && irqMask), "R12 irq", irqOut, mSticky && irqMask);
  endtask

  task automatic runBits(input int n, input real flipProb);
    for (int i = 0; i < n; i++) begin
      bit f;
      f = ($urandom_range(9999) < int'(flipProb * 10000.0));
      step(1, $urandom_range(1), srcBit(f), 0, 0);
    end
  endtask

  task automatic alignWindow();
    while (winCnt != 0) step(1, 0, srcBit(0), 0, 0);
  endtask

  // a window with the given number of errors at its start
  task automatic errWindow(input int nErr);
    alignWindow();
    for (int i = 0; i < 64; i++) step(1, 0, srcBit(i >= 3 && i < 3 + nErr), 0, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    int cBefore;
    bit txHold;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check(txDataOut == 0, "R1 tx", txDataOut, 0);
    check(syncFlag == 0, "R1 sync", syncFlag, 0);
    check(errCount == 0, "R1 count", errCount, 0);
    check(irqOut == 0, "R1 irq", irqOut, 0);

    // R2 fixed levels and pass-through
    patMode = 2'b01; step(1, 0, srcBit(0), 0, 0);
    check(txDataOut == 1, "R2 ones", txDataOut, 1);
    patMode = 2'b00; clkSel = 1; step(1, 1, srcBit(0), 0, 0);
    check(txDataOut == 0, "R2 zeros", txDataOut, 0);
    clkSel = 0; step(1, 1, srcBit(0), 0, 0);
    check(txDataOut == 1, "R2 pass", txDataOut, 1);
    patMode = 2'b11; step(1, 0, srcBit(0), 0, 0);
    check(txDataOut == 0, "R2 reserved pass", txDataOut, 0);

    // R13 no bitEn, no change
    txHold = txDataOut;
    for (int i = 0; i < 5; i++) step(0, ~txHold, 0, 0, 0);
    check(txDataOut == txHold, "R13 hold", txDataOut, txHold);

    // R3 short sequence, R8 self-lock, R11 rising edge
    patMode = 2'b10; irqAnyEdge = 0;
    runBits(256, 0.0);
    check(syncFlag == 1, "R8 self lock", syncFlag, 1);
    check(irqOut == 1, "R11 rise captured", irqOut, 1);
    step(0, 0, 0, 1, 0);
    check(irqOut == 0, "R12 sticky cleared", irqOut, 0);

    // R6 / R7 thresholds
    cBefore = mCnt;
    errWindow(6);
    check(syncFlag == 1, "R6 six errors keep sync", syncFlag, 1);
    check(errCount == cBefore + 6, "R9 six counted", errCount, cBefore + 6);
    errWindow(7);
    check(syncFlag == 0, "R7 seven errors drop sync", syncFlag, 0);
    check(irqOut == 0, "R11 fall ignored", irqOut, 0);
    runBits(192, 0.0);
    check(syncFlag == 1, "R8 relock", syncFlag, 1);
    irqAnyEdge = 1; step(0, 0, 0, 1, 0);
    errWindow(7);
    check(irqOut == 1, "R11 any change captured", irqOut, 1);
    irqMask = 0; step(0, 0, 0, 0, 0);
    check(irqOut == 0, "R12 masked", irqOut, 0);
    irqMask = 1; step(0, 0, 0, 1, 0);

    // R5 inversion on both sides, relock after flip
    patInvert = 1;
    runBits(320, 0.0);
    check(syncFlag == 1, "R5 inverted lock", syncFlag, 1);

    // R4 long sequence
    longSeq = 1;
    runBits(2000, 0.0);
    check(syncFlag == 1, "R4 long lock", syncFlag, 1);

    // random mix
    for (int i = 0; i < 4000; i++) begin
      bit en, f;
      if ($urandom_range(199) == 0) patMode = 2'($urandom_range(3));
      if ($urandom_range(299) == 0) longSeq = ~longSeq;
      if ($urandom_range(299) == 0) patInvert = ~patInvert;
      if ($urandom_range(99) == 0) irqAnyEdge = ~irqAnyEdge;
      if ($urandom_range(49) == 0) irqMask = ~irqMask;
      if ($urandom_range(99) == 0) errSel = ($urandom_range(3) == 0) ? 2'($urandom_range(3)) : 2'b00;
      if ($urandom_range(99) == 0) clkSel = ~clkSel;
      en = ($urandom_range(9) < 7);
      f = ($urandom_range(99) == 0);
      step(en, $urandom_range(1), en ? srcBit(f) : 1'b0,
           $urandom_range(149) == 0, $urandom_range(199) == 0);
    end

    // R9 saturation with a stream that misses every bit
    patMode = 2'b00; longSeq = 0; patInvert = 0; errSel = 2'b00;
    step(0, 0, 0, 0, 1);
    for (int i = 0; i < 66000; i++) step(1, 0, 1, 0, 0);
    check(errCount == 16'hFFFF, "R9 saturate", errCount, 16'hFFFF);
    // R10 clear wins over a same-cycle error
    step(1, 0, 1, 0, 1);
    check(errCount == 0, "R10 clear priority", errCount, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end
endmodule